// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers 29 peripheral interrupt lines into one request towards an upstream interrupt controller. A rising edge on a source line latches a pending bit. A per-source enable mask decides which pending sources count. While any source is both pending and enabled, the block drives a request on one of eight request levels. Software selects that level, and the request is presented as a one-hot vector.

Priority among the sources is resolved inside the block. By default a higher source index wins. A four-source group of serial-channel lines (indices 24 to 27) can be rearranged into one of four fixed orders. Software can also name one source that beats all others.

When the processor takes the interrupt, it writes 1 to the acknowledge bit of the vector register. That write captures the 5-bit number of the current winner. The acknowledge bit then drops by itself on the following cycle. Software reads the captured number to dispatch its handler, then clears the pending bit by writing 1 to it.

Top module: `vpic_top`

## Requirements
- R1: Each of the 29 `src_evt` bits sets its pending bit on a 0-to-1 transition only. A line that is held high does not set the bit again once software has cleared it.
- R2: Writing register 1 (pending) clears every pending bit whose data bit is 1. If a rising event on a source arrives in the same cycle as its clear, the event wins and the bit stays 1.
- R3: Register 2 is the enable mask, where a 1 enables a source. A pending source whose enable bit is 0 never raises the request and never wins arbitration.
- R4: `irq_lvl` is all zeros when no source is both pending and enabled. Otherwise exactly one bit is set: the bit indexed by the level field, bits [2:0] of register 0 (configuration).
- R5: Writing 1 to bit 0 of register 3 (vector) loads bits [5:1] with the number of the winning source. It also sets bit 0, which reads 1 for one cycle and 0 after that.
- R6: With the override and the group order left at their reset values, a higher source index has higher priority, and source 28 is the highest.
- R7: Bits [8:4] of register 0 name an override source. When that source is pending and enabled, it wins over every other source.
- R8: Bits [10:9] of register 0 set the order of sources 24 to 27, with p = index - 24 and the highest p' winning. The value 0 gives p' = p, 1 gives 3-p, 2 gives (p+1) mod 4 and 3 gives (p+2) mod 4. The group stays above sources 0 to 23 and below 28, and the override still applies on top of this order.
- R9: An acknowledge with no source pending and enabled loads the vector field with 0, and the request stays low.
- R10: After reset, pending, mask and vector all read 0. Register 0 reads 0x1C0: level 0, override source 28, group order 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_evt | input | 29 | Source event lines |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 2 | Register select: 0 config, 1 pending, 2 mask, 3 vector |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq_lvl | output | 8 | One-hot request level, zero when idle |

## Verification
The bench walks through every group order. It pits each reordered group member against its neighbours, so a wrong permutation table or a wrong group range returns the wrong vector. It makes the override target win against source 28 and then masks that target, which catches an override that ignores the mask. It fires an event in the same cycle as its clear, holds a line high across a clear, and acknowledges with nothing pending. A design with the clear winning, with a level-sensitive pending latch, or with a stale vector would each show a wrong pending or vector readback.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
    localparam int NSRC   = 29;
    localparam int VW     = 5;
    localparam int LVLS   = 8;
    localparam int LW     = $clog2(LVLS);
    localparam int GRP_LO = 24;
    localparam int GRP_N  = 4;
    localparam int RW     = VW + 1;

    typedef struct packed {
        logic [1:0]    ord;
        logic [VW-1:0] hp;
        logic [LW-1:0] lvl;
    } cfg_t;

    // rank of a source: larger wins; override gets a rank above all others
    function automatic logic [RW-1:0] src_rank(input int idx, input logic [1:0] ord,
                                               input logic [VW-1:0] hp);
        logic [1:0] p;
        logic [1:0] q;
        if (idx == int'(hp)) return RW'(NSRC);
        if (idx >= GRP_LO && idx < GRP_LO + GRP_N) begin
            p = 2'(idx - GRP_LO);
            case (ord)
                2'd0:    q = p;
                2'd1:    q = 2'd3 - p;
                2'd2:    q = p + 2'd1;
                default: q = p + 2'd2;
            endcase
            return RW'(GRP_LO) + RW'(q);
        end
        return RW'(idx);
    endfunction
endpackage

// File: rtl/vpic_pending.sv
module vpic_pending
    import vpic_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_evt,
    input  logic            clr_we,
    input  logic [NSRC-1:0] clr_bits,
    output logic [NSRC-1:0] pend
);
    typedef struct packed {
        logic [NSRC-1:0] prev;
        logic [NSRC-1:0] pend;
    } st_t;

    st_t st_d, st_q;
    logic [NSRC-1:0] rise;

    always_comb begin
        rise      = src_evt & ~st_q.prev;
        st_d.prev = src_evt;
        st_d.pend = (st_q.pend & ~(clr_we ? clr_bits : '0)) | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((pend & $past(rise)) == $past(rise)));  // R1
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((pend & $past(clr_bits & ~rise)) == '0));  // R2
endmodule

// File: rtl/vpic_arbiter.sv
module vpic_arbiter
    import vpic_pkg::*;
(
    input  logic [NSRC-1:0] active,
    input  logic [1:0]      ord,
    input  logic [VW-1:0]   hp,
    output logic            any,
    output logic [VW-1:0]   winner
);
    logic [RW-1:0] best;
    logic [RW-1:0] r;

    always_comb begin
        any    = 1'b0;
        winner = '0;
        best   = '0;
        r      = '0;
        for (int i = 0; i < NSRC; i++) begin
            r = src_rank(i, ord, hp);
            if (active[i] && (!any || r > best)) begin
                any    = 1'b1;
                best   = r;
                winner = VW'(i);
            end
        end
    end
endmodule

// File: rtl/vpic_top.sv
module vpic_top
    import vpic_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [28:0] src_evt,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic [7:0]  irq_lvl
);
    localparam logic [1:0] A_CFG = 2'd0;
    localparam logic [1:0] A_PND = 2'd1;
    localparam logic [1:0] A_MSK = 2'd2;
    localparam logic [1:0] A_VEC = 2'd3;

    typedef struct packed {
        cfg_t            cfg;
        logic [NSRC-1:0] mask;
        logic            ack;
        logic [VW-1:0]   vec;
    } st_t;

    st_t st_d, st_q;
    logic [NSRC-1:0] pend, active;
    logic            wr, any;
    logic [VW-1:0]   winner;

    assign wr = bus_sel && bus_wr;

    vpic_pending u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_evt  (src_evt),
        .clr_we   (wr && bus_addr == A_PND),
        .clr_bits (bus_wdata[NSRC-1:0]),
        .pend     (pend)
    );

    assign active = pend & st_q.mask;

    vpic_arbiter u_arb (
        .active (active),
        .ord    (st_q.cfg.ord),
        .hp     (st_q.cfg.hp),
        .any    (any),
        .winner (winner)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ack = 1'b0;
        if (wr) begin
            case (bus_addr)
                A_CFG: begin
                    st_d.cfg.lvl = bus_wdata[LW-1:0];
                    st_d.cfg.hp  = bus_wdata[4 +: VW];
                    st_d.cfg.ord = bus_wdata[10:9];
                end
                A_MSK: st_d.mask = bus_wdata[NSRC-1:0];
                A_VEC: if (bus_wdata[0]) begin
                    st_d.ack = 1'b1;
                    st_d.vec = any ? winner : '0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.cfg.hp <= VW'(NSRC - 1);
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CFG: bus_rdata = {21'b0, st_q.cfg.ord, st_q.cfg.hp, 1'b0, st_q.cfg.lvl};
            A_PND: bus_rdata = {3'b0, pend};
            A_MSK: bus_rdata = {3'b0, st_q.mask};
            default: bus_rdata = {26'b0, st_q.vec, st_q.ack};
        endcase
    end

    always_comb begin
        irq_lvl = '0;
        if (active != '0) irq_lvl[st_q.cfg.lvl] = 1'b1;
    end

    AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_lvl));  // R4
    AST_REQ_AT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lvl != '0) |-> irq_lvl[st_q.cfg.lvl]);  // R4
    AST_ACK_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ack |=> !st_q.ack);  // R5
    AST_WINNER_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (active[winner] && (pend[winner] && st_q.mask[winner])));  // R3
    AST_IDLE_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == A_VEC && bus_wdata[0] && active == '0) |=> (st_q.vec == '0));  // R9
endmodule

// File: tb/sim_vpic_top.sv
module sim_vpic_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [28:0] src_evt = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  irq_lvl;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    vpic_top u0 (.*);

    // lvl, hp, ord, mask, events, expected vector
    typedef struct packed {
        logic [2:0]  lvl;
        logic [4:0]  hp;
        logic [1:0]  ord;
        logic [28:0] mask;
        logic [28:0] evt;
        logic [4:0]  exp;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{3'd1, 5'd28, 2'd0, 29'h1FFF_FFFF, 29'h0000_0408, 5'd10},  // R6
        '{3'd2, 5'd28, 2'd0, 29'h1FFF_FFFF, 29'h0000_0022, 5'd5},   // R6
        '{3'd3, 5'd28, 2'd0, 29'h1FFF_FFFF, 29'h1800_0004, 5'd28},  // R6
        '{3'd4, 5'd28, 2'd1, 29'h1FFF_FFFF, 29'h0900_0000, 5'd24},  // R8
        '{3'd5, 5'd28, 2'd2, 29'h1FFF_FFFF, 29'h0C00_0000, 5'd26},  // R8
        '{3'd6, 5'd28, 2'd3, 29'h1FFF_FFFF, 29'h0700_0000, 5'd25},  // R8
        '{3'd7, 5'd3,  2'd0, 29'h1FFF_FFFF, 29'h1000_0008, 5'd3},   // R7
        '{3'd0, 5'd3,  2'd0, 29'h1FFF_FFF7, 29'h0010_0008, 5'd20},  // R7 R3
        '{3'd1, 5'd25, 2'd1, 29'h1FFF_FFFF, 29'h0600_0000, 5'd25},  // R7 R8
        '{3'd2, 5'd28, 2'd0, 29'h0000_0080, 29'h0000_0280, 5'd7}    // R3
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse(input logic [28:0] e);
        src_evt = e;
        @(negedge clk);
        src_evt = '0;
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        rd(2'd0, r); chk("R10 cfg", r, 32'h1C0);
        rd(2'd1, r); chk("R10 pend", r, 0);
        rd(2'd2, r); chk("R10 mask", r, 0);
        rd(2'd3, r); chk("R10 vec", r, 0);
        chk("R10 irq", {24'b0, irq_lvl}, 0);

        for (int i = 0; i < NV; i++) begin
            wr(2'd1, 32'h1FFF_FFFF);
            wr(2'd0, {21'b0, TBL[i].ord, TBL[i].hp, 1'b0, TBL[i].lvl});
            wr(2'd2, {3'b0, TBL[i].mask});
            pulse(TBL[i].evt);
            chk("R4 level", {24'b0, irq_lvl}, 32'(8'h1 << TBL[i].lvl));
            wr(2'd3, 32'h1);
            rd(2'd3, r);
            chk("R5 R6 R7 R8 vector+ack", r, {26'b0, TBL[i].exp, 1'b1});
            @(negedge clk);
            rd(2'd3, r);
            chk("R5 ack cleared", r, {26'b0, TBL[i].exp, 1'b0});
        end

        // R3 masked pending raises nothing
        wr(2'd0, 32'h1C5);
        wr(2'd1, 32'h1FFF_FFFF);
        wr(2'd2, 32'h0);
        pulse(29'h0000_0100);
        rd(2'd1, r); chk("R3 pend latched", r, 32'h100);
        chk("R3 masked irq", {24'b0, irq_lvl}, 0);

        // R9 idle acknowledge loads zero
        wr(2'd3, 32'h1);
        rd(2'd3, r); chk("R9 idle vector", r, 32'h1);
        chk("R9 irq low", {24'b0, irq_lvl}, 0);

        // R1 held-high line does not re-set after clear
        wr(2'd1, 32'h1FFF_FFFF);
        src_evt = 29'h10;
        @(negedge clk);
        rd(2'd1, r); chk("R1 edge sets", r, 32'h10);
        wr(2'd1, 32'h10);
        @(negedge clk);
        rd(2'd1, r); chk("R1 held no reset", r, 0);
        src_evt = '0;
        @(negedge clk);
        pulse(29'h10);
        rd(2'd1, r); chk("R1 new edge", r, 32'h10);

        // R2 event in the clear cycle wins; plain clear removes bit
        wr(2'd1, 32'h1FFF_FFFF);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 32'h40;
        src_evt = 29'h40;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0; src_evt = '0;
        rd(2'd1, r); chk("R2 event beats clear", r, 32'h40);
        wr(2'd1, 32'h40);
        rd(2'd1, r); chk("R2 clear", r, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule